// File: doc/BRIEF.md
# Software Write-Protection Sequence Guard

This block sits between a host write port and the page-load controller of a byte-alterable nonvolatile memory. It watches each byte write (address and data) and decides whether the write may reach the array. Certain writes are not data. They are command steps: a short key sequence arms protection and opens a single page-load window, and a longer key sequence turns protection off again. Once protection is on, ordinary writes are discarded unless a key sequence comes right before them. When the page-load controller reports that the load has finished, the window closes and protection takes over again.

The protection flag models a nonvolatile bit. The `rst_n` input stands for the factory-fresh initialisation and clears the flag. The `pwr_good` input stands for the supply-sense comparator. While it is low, every write is blocked, any sequence in progress is dropped and the window closes. The protection flag keeps its value through that low period. A granted write comes out one clock after it is presented, together with its address and data.

Top module: `sdp_guard`

## Requirements
- R1: After reset, protection is off, the load window is closed and no grant is issued.
- R2: With protection off and no sequence step matched, a write is granted in the next cycle, and `grant_addr`/`grant_data` equal the presented address and data.
- R3: Three consecutive writes, data 0xAA at address 0x5555, data 0x55 at address 0x2AAA, then data 0xA0 at address 0x5555, turn protection on and open the load window. None of these three writes is granted.
- R4: While the load window is open, every write is granted, including writes that look like command steps. A `load_done` pulse closes the window.
- R5: With protection on and the window closed, a write that is not a matched sequence step is discarded (no grant).
- R6: Six consecutive writes clear protection: 0xAA@0x5555, 0x55@0x2AAA, 0x80@0x5555, 0xAA@0x5555, 0x55@0x2AAA, 0x20@0x5555. None of them is granted.
- R7: A write that does not match the next expected step aborts the sequence. If that write is 0xAA@0x5555 it becomes step one of a new sequence and is not granted. Otherwise it is handled as an ordinary write.
- R8: While `pwr_good` is low, no write is granted, the sequence returns to idle and the window closes. The protection flag does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset (factory-fresh state) |
| pwr_good | input | 1 | Supply above write threshold |
| wr_valid | input | 1 | One-cycle byte write strobe |
| wr_addr | input | 15 | Write address |
| wr_data | input | 8 | Write data |
| load_done | input | 1 | Page-load controller reports end of load |
| wr_grant | output | 1 | Write forwarded to array (one cycle after strobe) |
| grant_addr | output | 15 | Address of granted write |
| grant_data | output | 8 | Data of granted write |
| prot_on | output | 1 | Protection flag |
| load_window | output | 1 | Page-load window open |

## Verification
The bench runs both key sequences and interrupts them partway. One case breaks a sequence with a restart step: a design that drops the breaking write instead of restarting would fail to open the window afterwards. Another case uses a wrong address in the middle step, and a design that compares too few address bits would arm protection there. Writes that look like commands are sent inside an open window, which catches a design that keeps decoding while the window is open. A supply dip is applied with protection on. A design that clears the flag, or leaves the window open across the dip, would then grant a write that it must discard.

// File: rtl/sdp_pkg.sv
package sdp_pkg;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_K1,
        SQ_K2,
        SQ_K3,
        SQ_K4,
        SQ_K5
    } seq_t;

    typedef struct packed {
        logic aa_lo;
        logic h55_hi;
        logic a0_lo;
        logic h80_lo;
        logic h20_lo;
    } hits_t;

endpackage

// File: rtl/sdp_cmd_decode.sv
module sdp_cmd_decode #(
    parameter int AW = 15,
    parameter int DW = 8,
    parameter logic [AW-1:0] KEY_ADDR_LO = AW'('h5555),
    parameter logic [AW-1:0] KEY_ADDR_HI = AW'('h2AAA),
    parameter logic [DW-1:0] KEY_D_AA    = DW'('hAA),
    parameter logic [DW-1:0] KEY_D_55    = DW'('h55),
    parameter logic [DW-1:0] KEY_D_ARM   = DW'('hA0),
    parameter logic [DW-1:0] KEY_D_EXT   = DW'('h80),
    parameter logic [DW-1:0] KEY_D_OFF   = DW'('h20)
) (
    input  logic [AW-1:0]  addr,
    input  logic [DW-1:0]  data,
    output sdp_pkg::hits_t hits
);
    logic at_lo;
    logic at_hi;

    assign at_lo = (addr == KEY_ADDR_LO);
    assign at_hi = (addr == KEY_ADDR_HI);

    always_comb begin
        hits.aa_lo  = at_lo && (data == KEY_D_AA);
        hits.h55_hi = at_hi && (data == KEY_D_55);
        hits.a0_lo  = at_lo && (data == KEY_D_ARM);
        hits.h80_lo = at_lo && (data == KEY_D_EXT);
        hits.h20_lo = at_lo && (data == KEY_D_OFF);
    end
endmodule

// File: rtl/sdp_seq_fsm.sv
module sdp_seq_fsm (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           pwr_good,
    input  logic           wr_valid,
    input  logic           win_open,
    input  sdp_pkg::hits_t hits,
    output logic           consumed,
    output logic           arm,
    output logic           disarm
);
    import sdp_pkg::*;

    typedef struct packed {
        seq_t st;
    } fsm_t;

    fsm_t s_q, s_d;
    logic live;

    assign live = wr_valid && pwr_good && !win_open;

    always_comb begin
        s_d      = s_q;
        consumed = 1'b0;
        arm      = 1'b0;
        disarm   = 1'b0;
        if (!pwr_good) begin
            s_d.st = SQ_IDLE;
        end else if (live) begin
            // default: abort, possibly restarting on a first-step write
            s_d.st   = hits.aa_lo ? SQ_K1 : SQ_IDLE;
            consumed = hits.aa_lo;
            unique case (s_q.st)
                SQ_IDLE: ;
                SQ_K1: if (hits.h55_hi) begin
                    s_d.st = SQ_K2; consumed = 1'b1;
                end
                SQ_K2: if (hits.a0_lo) begin
                    s_d.st = SQ_IDLE; consumed = 1'b1; arm = 1'b1;
                end else if (hits.h80_lo) begin
                    s_d.st = SQ_K3; consumed = 1'b1;
                end
                SQ_K3: if (hits.aa_lo) begin
                    s_d.st = SQ_K4; consumed = 1'b1;
                end
                SQ_K4: if (hits.h55_hi) begin
                    s_d.st = SQ_K5; consumed = 1'b1;
                end
                SQ_K5: if (hits.h20_lo) begin
                    s_d.st = SQ_IDLE; consumed = 1'b1; disarm = 1'b1;
                end
                default: s_d.st = SQ_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{st: SQ_IDLE};
        else        s_q <= s_d;
    end
endmodule

// File: rtl/sdp_guard.sv
module sdp_guard #(
    parameter int AW = 15,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pwr_good,
    input  logic          wr_valid,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic          load_done,
    output logic          wr_grant,
    output logic [AW-1:0] grant_addr,
    output logic [DW-1:0] grant_data,
    output logic          prot_on,
    output logic          load_window
);
    import sdp_pkg::*;

    typedef struct packed {
        logic          prot;
        logic          win;
        logic          grant;
        logic [AW-1:0] gaddr;
        logic [DW-1:0] gdata;
    } st_t;

    st_t   r_q, r_d;
    hits_t hits;
    logic  consumed, arm, disarm;

    sdp_cmd_decode #(.AW(AW), .DW(DW)) u_dec (
        .addr (wr_addr),
        .data (wr_data),
        .hits (hits)
    );

    sdp_seq_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .pwr_good (pwr_good),
        .wr_valid (wr_valid),
        .win_open (r_q.win),
        .hits     (hits),
        .consumed (consumed),
        .arm      (arm),
        .disarm   (disarm)
    );

    always_comb begin
        r_d       = r_q;
        r_d.grant = wr_valid && pwr_good && !consumed && (!r_q.prot || r_q.win);
        if (r_d.grant) begin
            r_d.gaddr = wr_addr;
            r_d.gdata = wr_data;
        end
        if (arm)         r_d.prot = 1'b1;
        else if (disarm) r_d.prot = 1'b0;
        if (!pwr_good)     r_d.win = 1'b0;
        else if (arm)      r_d.win = 1'b1;
        else if (load_done) r_d.win = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign wr_grant    = r_q.grant;
    assign grant_addr  = r_q.gaddr;
    assign grant_data  = r_q.gdata;
    assign prot_on     = r_q.prot;
    assign load_window = r_q.win;
endmodule

// File: rtl/sdp_guard_chk.sv
module sdp_guard_chk #(
    parameter int AW = 15,
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          pwr_good,
    input logic          wr_valid,
    input logic [AW-1:0] wr_addr,
    input logic [DW-1:0] wr_data,
    input logic          wr_grant,
    input logic [AW-1:0] grant_addr,
    input logic [DW-1:0] grant_data,
    input logic          prot_on,
    input logic          load_window
);
    a_r2_no_grant_without_write: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_valid |=> !wr_grant);

    a_r2_grant_echo: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |=> (!wr_grant || (grant_addr == $past(wr_addr) && grant_data == $past(wr_data))));

    a_r4_window_passes: assert property (@(posedge clk) disable iff (!rst_n)
        (load_window && wr_valid && pwr_good) |=> wr_grant);

    a_r5_protected_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (prot_on && !load_window) |=> !wr_grant);

    a_r8_no_grant_low_power: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_good |=> !wr_grant);

    a_r8_window_drops: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_good |=> !load_window);

    a_r8_flag_kept: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_good |=> $stable(prot_on));
endmodule

bind sdp_guard sdp_guard_chk #(.AW(AW), .DW(DW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .pwr_good    (pwr_good),
    .wr_valid    (wr_valid),
    .wr_addr     (wr_addr),
    .wr_data     (wr_data),
    .wr_grant    (wr_grant),
    .grant_addr  (grant_addr),
    .grant_data  (grant_data),
    .prot_on     (prot_on),
    .load_window (load_window)
);

// File: tb/sdp_guard_bench.sv
module sdp_guard_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pwr_good = 1'b1;
    logic        wr_valid = 1'b0;
    logic [14:0] wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic        load_done = 1'b0;
    logic        wr_grant, prot_on, load_window;
    logic [14:0] grant_addr;
    logic [7:0]  grant_data;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    sdp_guard u_sdp_guard (
        .clk(clk), .rst_n(rst_n), .pwr_good(pwr_good), .wr_valid(wr_valid),
        .wr_addr(wr_addr), .wr_data(wr_data), .load_done(load_done),
        .wr_grant(wr_grant), .grant_addr(grant_addr), .grant_data(grant_data),
        .prot_on(prot_on), .load_window(load_window)
    );

    typedef struct packed {
        logic        wv;
        logic        pg;
        logic        ld;
        logic [14:0] a;
        logic [7:0]  d;
        logic        eg;
        logic        ep;
    } vec_t;

    localparam int NV = 19;
    localparam vec_t VEC [NV] = '{
        '{1'b1,1'b1,1'b0,15'h0100,8'h11,1'b1,1'b0},  // R2 plain write
        '{1'b1,1'b1,1'b0,15'h5555,8'hAA,1'b0,1'b0},  // R3 step 1
        '{1'b1,1'b1,1'b0,15'h2AAA,8'h55,1'b0,1'b0},  // R3 step 2
        '{1'b1,1'b1,1'b0,15'h5555,8'hA0,1'b0,1'b1},  // R3 arm
        '{1'b1,1'b1,1'b0,15'h0200,8'h22,1'b1,1'b1},  // R4 window
        '{1'b1,1'b1,1'b0,15'h0201,8'h23,1'b1,1'b1},  // R4 window
        '{1'b0,1'b1,1'b1,15'h0000,8'h00,1'b0,1'b1},  // R4 close
        '{1'b1,1'b1,1'b0,15'h0300,8'h33,1'b0,1'b1},  // R5 blocked
        '{1'b1,1'b1,1'b0,15'h5555,8'hAA,1'b0,1'b1},  // R7 step 1
        '{1'b1,1'b1,1'b0,15'h0000,8'h44,1'b0,1'b1},  // R7 break, R5 blocked
        '{1'b1,1'b1,1'b0,15'h2AAA,8'h55,1'b0,1'b1},  // R7 out of order
        '{1'b1,1'b1,1'b0,15'h5555,8'hAA,1'b0,1'b1},  // R6 1
        '{1'b1,1'b1,1'b0,15'h2AAA,8'h55,1'b0,1'b1},  // R6 2
        '{1'b1,1'b1,1'b0,15'h5555,8'h80,1'b0,1'b1},  // R6 3
        '{1'b1,1'b1,1'b0,15'h5555,8'hAA,1'b0,1'b1},  // R6 4
        '{1'b1,1'b1,1'b0,15'h2AAA,8'h55,1'b0,1'b1},  // R6 5
        '{1'b1,1'b1,1'b0,15'h5555,8'h20,1'b0,1'b0},  // R6 6
        '{1'b1,1'b1,1'b0,15'h0400,8'h55,1'b1,1'b0},  // R2 after disable
        '{1'b1,1'b0,1'b0,15'h0500,8'h66,1'b0,1'b0}   // R8 low supply
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // drive at a falling edge, let one rising edge pass, return at the next falling edge
    task automatic step(input logic wv, input logic pg, input logic ld,
                        input logic [14:0] a, input logic [7:0] d);
        wr_valid = wv; pwr_good = pg; load_done = ld; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_valid = 1'b0; load_done = 1'b0;
    endtask

    task automatic wr(input logic [14:0] a, input logic [7:0] d);
        step(1'b1, 1'b1, 1'b0, a, d);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: actual=running expected=finished");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 grant", wr_grant, 0);
        chk("R1 prot", prot_on, 0);
        chk("R1 window", load_window, 0);

        for (int i = 0; i < NV; i++) begin
            step(VEC[i].wv, VEC[i].pg, VEC[i].ld, VEC[i].a, VEC[i].d);
            chk($sformatf("R2-vector %0d grant", i), wr_grant, VEC[i].eg);
            chk($sformatf("R3/R6 vector %0d prot", i), prot_on, VEC[i].ep);
            if (VEC[i].eg) begin
                chk("R2 grant_addr", grant_addr, VEC[i].a);
                chk("R2 grant_data", grant_data, VEC[i].d);
            end
        end

        // R8: supply dip with protection on and window open
        step(1'b0, 1'b1, 1'b0, '0, '0);
        wr(15'h5555, 8'hAA); wr(15'h2AAA, 8'h55); wr(15'h5555, 8'hA0);
        chk("R3 window open", load_window, 1);
        step(1'b0, 1'b0, 1'b0, '0, '0);
        step(1'b0, 1'b0, 1'b0, '0, '0);
        chk("R8 window closed by dip", load_window, 0);
        chk("R8 flag kept", prot_on, 1);
        wr(15'h0600, 8'h77);
        chk("R8 no window after dip", wr_grant, 0);

        // R4: command-looking writes pass inside the window
        wr(15'h5555, 8'hAA); wr(15'h2AAA, 8'h55); wr(15'h5555, 8'hA0);
        wr(15'h5555, 8'hAA);
        chk("R4 command-like write granted", wr_grant, 1);
        chk("R4 grant_data", grant_data, 8'hAA);
        step(1'b0, 1'b1, 1'b1, '0, '0);
        chk("R4 load_done closes", load_window, 0);

        // R7: break with a first-step write restarts
        wr(15'h5555, 8'hAA); wr(15'h2AAA, 8'h55); wr(15'h5555, 8'h80);
        wr(15'h5555, 8'hAA); wr(15'h5555, 8'hAA);
        chk("R7 restart write not granted", wr_grant, 0);
        wr(15'h2AAA, 8'h55); wr(15'h5555, 8'hA0);
        chk("R7 restart arms window", load_window, 1);
        step(1'b0, 1'b1, 1'b1, '0, '0);

        // R7/R5: wrong middle address does not arm
        wr(15'h5555, 8'hAA); wr(15'h2AAB, 8'h55); wr(15'h5555, 8'hA0);
        chk("R7 wrong address no window", load_window, 0);
        chk("R5 wrong address no grant", wr_grant, 0);

        // disable, then a broken step in unprotected mode passes the breaking write
        wr(15'h5555, 8'hAA); wr(15'h2AAA, 8'h55); wr(15'h5555, 8'h80);
        wr(15'h5555, 8'hAA); wr(15'h2AAA, 8'h55); wr(15'h5555, 8'h20);
        chk("R6 protection cleared", prot_on, 0);
        wr(15'h5555, 8'hAA);
        chk("R7 step 1 consumed", wr_grant, 0);
        wr(15'h0700, 8'h12);
        chk("R7 breaking write granted", wr_grant, 1);
        chk("R7 grant_addr", grant_addr, 15'h0700);

        finish_run();
    end
endmodule